// File: doc/BRIEF.md
# Coprocessor-0 Status/Cause Exception Controller

This block is the system-control register set beside a MIPS-style integer pipeline. It keeps three architectural registers (Status, Cause and the saved exception PC), serves the move-to and move-from accesses that software makes to them by register number, and decides when the core must take an exception. Two sources of exception exist: a syscall strobe from the decoder, and the two software-interrupt pending bits in Cause once they meet their enables in Status.

A small sequencer with three named states runs the block. `ST_RUN` accepts one strobe per cycle. Several transitions leave it: a syscall goes to `ST_TRAP`; a write to Status or Cause goes to `ST_EVAL`; a return-from-exception or any other write stays in `ST_RUN`. In `ST_EVAL` the block checks the software-interrupt condition against the freshly written values. If the condition holds it goes to `ST_TRAP`; if not, it goes back to `ST_RUN`. `ST_TRAP` always returns to `ST_RUN` after one cycle. The registers take their exception-entry values on the edge that enters `ST_TRAP`, and the exception request output is high for the one cycle spent there.

The return-from-exception strobe pops the three-level mode/enable stack held in the low six Status bits. Exception entry pushes onto the same stack. The vector-select output follows Status bit 22, so the core can pick between its normal and its boot-time handler address.

Top module: `cp0_sysctl`

## Requirements
- R1: After reset, Status, Cause and the saved PC all read as zero, and the exception request is low.
- R2: A read of register number 12, 13 or 14 returns Status, Cause or the saved PC. Any other register number reads as zero, and a write to any other number changes none of the three registers.
- R3: A write to register 12 loads all 32 bits of Status. A write to register 14 loads all 32 bits of the saved PC. Both are visible one cycle after the write.
- R4: A write to register 13 changes only Cause bits 9:8. Every other Cause bit keeps its value.
- R5: After a write to register 12 or 13, the block evaluates the software-interrupt condition in the following cycle. The condition is that (Cause AND Status AND 0x300) is nonzero and Status bit 0 is 1. When it holds, the exception request is high in the second cycle after the write, and Cause bits 6:2 hold 0.
- R6: A syscall strobe raises the exception request in the next cycle. Cause bits 6:2 then hold 8 (field value 0x20), and the saved PC equals the PC presented with the strobe.
- R7: On exception entry, Status bits 5:0 take the old bits 3:0 shifted up by two, with bits 1:0 cleared. Status bits 31:6 are unchanged.
- R8: On exception entry, Cause bit 31 takes the in-delay-slot flag. When the flag is set, the saved PC is the presented PC minus 4.
- R9: A return-from-exception strobe copies Status bits 5:2 into bits 3:0 one cycle later. Status bits 31:4 are unchanged, and no exception is requested.
- R10: The exception request is high for exactly one cycle per exception, and no register changes during that cycle's closing edge.
- R11: In `ST_RUN` a syscall takes priority over a return-from-exception, and both take priority over a register write presented in the same cycle.
- R12: Strobes presented while the block is in `ST_EVAL` or `ST_TRAP` are ignored.
- R13: The vector-select output equals Status bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the instruction being accepted or interrupted |
| in_delay_i | input | 1 | That instruction sits in a branch delay slot |
| syscall_i | input | 1 | Syscall strobe |
| rfe_i | input | 1 | Return-from-exception strobe |
| reg_addr_i | input | ADDR_W | Register number for read and write |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| exc_req_o | output | 1 | One-cycle exception request |
| vec_sel_o | output | 1 | Exception vector select |
| epc_o | output | 32 | Saved exception PC |

## Verification
Each result has a fixed due cycle. Entry values and the request after a syscall are due one cycle after the strobe edge. A software interrupt that follows a Status or Cause write is due two cycles after the write edge, and the request has fallen again one cycle after that. Return-from-exception and plain register writes show on the read port one cycle after their edge. The bench drives every strobe on a falling edge and then waits exactly that number of falling edges before it samples. It reads all three registers back through the read port each time, and compares them with a model that its own tasks update from the requirements. In this way a random mix of writes, syscalls and pops never leaves the bench sampling in a transitional cycle.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_EVAL = 2'd1,
        ST_TRAP = 2'd2
    } cp0_state_e;

    localparam int IDX_STATUS = 12;
    localparam int IDX_CAUSE  = 13;
    localparam int IDX_EPC    = 14;

    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_INT     = 5'd0;
    localparam logic [CODE_W-1:0] CODE_SYSCALL = 5'd8;

    localparam logic [XLEN-1:0] CAUSE_WMASK = 32'h0000_0300;
    localparam int VEC_BIT = 22;
endpackage

// File: rtl/cp0_seq.sv
module cp0_seq
    import cp0_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                syscall,
    input  logic                rfe,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                swi_hit,
    output logic                take_trap,
    output logic [CODE_W-1:0]   trap_code,
    output logic                do_rfe,
    output logic                do_wr,
    output logic                exc_req,
    output logic                in_run,
    output logic                in_eval
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IDX_STATUS);
    localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(IDX_CAUSE);

    cp0_state_e state_q, state_d;
    logic       ctl_write;

    assign ctl_write = (addr == A_STATUS) || (addr == A_CAUSE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (syscall)                   state_d = ST_TRAP;
                else if (!rfe && wr_en && ctl_write) state_d = ST_EVAL;
                else                           state_d = ST_RUN;
            end
            ST_EVAL: state_d = swi_hit ? ST_TRAP : ST_RUN;
            ST_TRAP: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        take_trap = 1'b0;
        trap_code = CODE_INT;
        do_rfe    = 1'b0;
        do_wr     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (syscall) begin
                    take_trap = 1'b1;
                    trap_code = CODE_SYSCALL;
                end else if (rfe) begin
                    do_rfe = 1'b1;
                end else if (wr_en) begin
                    do_wr = 1'b1;
                end
            end
            ST_EVAL: begin
                if (swi_hit) begin
                    take_trap = 1'b1;
                    trap_code = CODE_INT;
                end
            end
            ST_TRAP: ;
            default: ;
        endcase
    end

    assign exc_req = (state_q == ST_TRAP);
    assign in_run  = (state_q == ST_RUN);
    assign in_eval = (state_q == ST_EVAL);
endmodule

// File: rtl/cp0_regs.sv
module cp0_regs
    import cp0_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_trap,
    input  logic [CODE_W-1:0]   trap_code,
    input  logic [XLEN-1:0]     pc,
    input  logic                in_delay,
    input  logic                do_rfe,
    input  logic                do_wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [XLEN-1:0]     wdata,
    output logic [XLEN-1:0]     status,
    output logic [XLEN-1:0]     cause,
    output logic [XLEN-1:0]     epc,
    output logic [XLEN-1:0]     rdata,
    output logic                swi_hit
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IDX_STATUS);
    localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(IDX_CAUSE);
    localparam logic [ADDR_W-1:0] A_EPC    = ADDR_W'(IDX_EPC);

    logic [XLEN-1:0] status_q, cause_q, epc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            cause_q  <= '0;
            epc_q    <= '0;
        end else if (take_trap) begin
            status_q[5:0] <= {status_q[3:0], 2'b00};
            cause_q[6:2]  <= trap_code;
            cause_q[31]   <= in_delay;
            epc_q         <= in_delay ? (pc - XLEN'(4)) : pc;
        end else if (do_rfe) begin
            status_q[3:0] <= status_q[5:2];
        end else if (do_wr) begin
            if (addr == A_STATUS)     status_q <= wdata;
            else if (addr == A_CAUSE) cause_q  <= (cause_q & ~CAUSE_WMASK) | (wdata & CAUSE_WMASK);
            else if (addr == A_EPC)   epc_q    <= wdata;
        end
    end

    always_comb begin
        if (addr == A_STATUS)     rdata = status_q;
        else if (addr == A_CAUSE) rdata = cause_q;
        else if (addr == A_EPC)   rdata = epc_q;
        else                      rdata = '0;
    end

    assign swi_hit = (|(cause_q[9:8] & status_q[9:8])) && status_q[0];
    assign status  = status_q;
    assign cause   = cause_q;
    assign epc     = epc_q;
endmodule

// File: rtl/cp0_sysctl.sv
module cp0_sysctl
    import cp0_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         pc_i,
    input  logic                in_delay_i,
    input  logic                syscall_i,
    input  logic                rfe_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                exc_req_o,
    output logic                vec_sel_o,
    output logic [31:0]         epc_o
);
    logic              take_trap, do_rfe, do_wr, swi_hit, run_w, eval_w;
    logic [CODE_W-1:0] trap_code;
    logic [XLEN-1:0]   status_w, cause_w, epc_w;

    cp0_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .syscall   (syscall_i),
        .rfe       (rfe_i),
        .wr_en     (reg_wr_i),
        .addr      (reg_addr_i),
        .swi_hit   (swi_hit),
        .take_trap (take_trap),
        .trap_code (trap_code),
        .do_rfe    (do_rfe),
        .do_wr     (do_wr),
        .exc_req   (exc_req_o),
        .in_run    (run_w),
        .in_eval   (eval_w)
    );

    cp0_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_trap (take_trap),
        .trap_code (trap_code),
        .pc        (pc_i),
        .in_delay  (in_delay_i),
        .do_rfe    (do_rfe),
        .do_wr     (do_wr),
        .addr      (reg_addr_i),
        .wdata     (reg_wdata_i),
        .status    (status_w),
        .cause     (cause_w),
        .epc       (epc_w),
        .rdata     (reg_rdata_o),
        .swi_hit   (swi_hit)
    );

    assign vec_sel_o = status_w[VEC_BIT];
    assign epc_o     = epc_w;
endmodule

// File: rtl/cp0_sysctl_chk.sv
module cp0_sysctl_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              eval,
    input logic              exc_req,
    input logic              syscall,
    input logic              rfe,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       pc,
    input logic              bd,
    input logic [31:0]       status,
    input logic [31:0]       cause,
    input logic [31:0]       epc
);
    // R10: request lasts one cycle, registers hold across it
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req);
    p_trap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> ($stable(status) && $stable(cause) && $stable(epc)));

    // R6 / R8: syscall entry values
    p_sys_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && syscall) |=> (exc_req && cause[6:2] == 5'd8 &&
            epc == ($past(bd) ? $past(pc) - 32'd4 : $past(pc))));

    // R9: stack pop
    p_rfe_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !syscall && rfe) |=> (status[3:0] == $past(status[5:2]) &&
            status[31:4] == $past(status[31:4]) && !exc_req));

    // R4: partial Cause write
    p_cause_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !syscall && !rfe && wr_en && addr == ADDR_W'(13)) |=>
            ((cause & ~32'h300) == ($past(cause) & ~32'h300)));

    // R5: software interrupt taken from evaluation state
    p_swi_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && status[0] && (|(cause[9:8] & status[9:8]))) |=>
            (exc_req && cause[6:2] == 5'd0));

    // R7: entry pushes the mode/enable stack
    p_entry_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && syscall) |=> (status[5:0] == {$past(status[3:0]), 2'b00} &&
            status[31:6] == $past(status[31:6])));
endmodule

bind cp0_sysctl cp0_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .eval    (eval_w),
    .exc_req (exc_req_o),
    .syscall (syscall_i),
    .rfe     (rfe_i),
    .wr_en   (reg_wr_i),
    .addr    (reg_addr_i),
    .pc      (pc_i),
    .bd      (in_delay_i),
    .status  (status_w),
    .cause   (cause_w),
    .epc     (epc_w)
);

// File: tb/sim_cp0_sysctl.sv
`timescale 1ns/1ps
module sim_cp0_sysctl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc_i;
    logic        in_delay_i, syscall_i, rfe_i, reg_wr_i;
    logic [4:0]  reg_addr_i;
    logic [31:0] reg_wdata_i, reg_rdata_o, epc_o;
    logic        exc_req_o, vec_sel_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] ms, mc, me;

    always #10 clk = ~clk;

    cp0_sysctl #(.ADDR_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .in_delay_i(in_delay_i),
        .syscall_i(syscall_i), .rfe_i(rfe_i), .reg_addr_i(reg_addr_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .exc_req_o(exc_req_o), .vec_sel_o(vec_sel_o), .epc_o(epc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic m_hit();
        return (|(mc[9:8] & ms[9:8])) && ms[0];
    endfunction

    task automatic m_entry(input logic [4:0] code, input logic [31:0] pc, input logic bd);
        ms[5:0] = {ms[3:0], 2'b00};
        mc[6:2] = code;
        mc[31]  = bd;
        me      = bd ? pc - 32'd4 : pc;
    endtask

    task automatic rd_chk(input string tag);
        reg_addr_i = 5'd12; #1 chk({tag, " R2 status"}, reg_rdata_o, ms);
        reg_addr_i = 5'd13; #1 chk({tag, " R2 cause"}, reg_rdata_o, mc);
        reg_addr_i = 5'd14; #1 chk({tag, " R2 epc"}, reg_rdata_o, me);
        reg_addr_i = 5'd3;  #1 chk({tag, " R2 unimpl"}, reg_rdata_o, 32'd0);
        chk({tag, " R8 epc_o"}, epc_o, me);
        chk({tag, " R13 vec_sel"}, {31'd0, vec_sel_o}, {31'd0, ms[22]});
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d,
                            input logic [31:0] pc, input logic bd, input string tag);
        logic hit;
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1; pc_i = pc; in_delay_i = bd;
        @(negedge clk);
        reg_wr_i = 1'b0;
        if (a == 5'd12)      ms = d;
        else if (a == 5'd13) mc = (mc & ~32'h300) | (d & 32'h300);
        else if (a == 5'd14) me = d;
        chk({tag, " R3 no req after write"}, {31'd0, exc_req_o}, 32'd0);
        if (a == 5'd12 || a == 5'd13) begin
            hit = m_hit();
            @(negedge clk);
            chk({tag, " R5 swi request"}, {31'd0, exc_req_o}, {31'd0, hit});
            if (hit) begin
                m_entry(5'd0, pc, bd);
                rd_chk({tag, " R5 R7 swi entry"});
                @(negedge clk);
                chk({tag, " R10 req fall"}, {31'd0, exc_req_o}, 32'd0);
            end
        end
        rd_chk(tag);
    endtask

    task automatic do_syscall(input logic [31:0] pc, input logic bd, input logic with_rfe,
                              input string tag);
        syscall_i = 1'b1; rfe_i = with_rfe; pc_i = pc; in_delay_i = bd;
        @(negedge clk);
        syscall_i = 1'b0; rfe_i = 1'b0;
        chk({tag, " R6 request"}, {31'd0, exc_req_o}, 32'd1);
        m_entry(5'd8, pc, bd);
        rd_chk({tag, " R6 R7 R8 R11 entry"});
        @(negedge clk);
        chk({tag, " R10 req fall"}, {31'd0, exc_req_o}, 32'd0);
    endtask

    task automatic do_rfe(input string tag);
        rfe_i = 1'b1;
        @(negedge clk);
        rfe_i = 1'b0;
        ms[3:0] = ms[5:2];
        chk({tag, " R9 no request"}, {31'd0, exc_req_o}, 32'd0);
        rd_chk({tag, " R9 pop"});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pc_i = '0; in_delay_i = 1'b0; syscall_i = 1'b0; rfe_i = 1'b0;
        reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        ms = '0; mc = '0; me = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset request", {31'd0, exc_req_o}, 32'd0);
        rd_chk("R1 reset");

        // full writes, masked Cause write, writes elsewhere
        do_write(5'd12, 32'h0040_003C, 32'h100, 1'b0, "R3 R13 status");
        do_write(5'd14, 32'hCAFE_F00C, 32'h104, 1'b0, "R3 epc");
        do_write(5'd13, 32'hFFFF_FCFF, 32'h108, 1'b0, "R4 cause mask");
        do_write(5'd7,  32'hFFFF_FFFF, 32'h10C, 1'b0, "R2 other write");

        // pop sequence
        do_rfe("R9 first");
        do_write(5'd12, 32'h0000_0024, 32'h110, 1'b0, "R9 setup");
        do_rfe("R9 second");
        do_rfe("R9 third");

        // syscall entries
        do_syscall(32'h0000_2000, 1'b0, 1'b0, "R6 plain");
        do_syscall(32'h0000_3004, 1'b1, 1'b0, "R8 delay slot");
        do_syscall(32'h0000_4000, 1'b0, 1'b1, "R11 with rfe");

        // software interrupt
        do_write(5'd13, 32'h0000_0100, 32'h500, 1'b0, "R5 pend no enable");
        do_write(5'd12, 32'h0000_0101, 32'h504, 1'b1, "R5 take");
        do_write(5'd12, 32'h0000_0200, 32'h508, 1'b0, "R5 masked");

        // R11: rfe beats write
        do_write(5'd12, 32'h0000_0030, 32'h600, 1'b0, "R11 setup");
        rfe_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 5'd14; reg_wdata_i = 32'h1234_5678;
        @(negedge clk);
        rfe_i = 1'b0; reg_wr_i = 1'b0;
        ms[3:0] = ms[5:2];
        rd_chk("R11 rfe over write");

        // R12: syscall during trap cycle ignored
        syscall_i = 1'b1; pc_i = 32'h700; in_delay_i = 1'b0;
        @(negedge clk);
        m_entry(5'd8, 32'h700, 1'b0);
        pc_i = 32'hDEAD_0000;
        @(negedge clk);
        syscall_i = 1'b0;
        chk("R12 trap ignore request", {31'd0, exc_req_o}, 32'd0);
        rd_chk("R12 trap ignore");

        // R12: syscall during evaluation cycle ignored
        reg_addr_i = 5'd12; reg_wdata_i = 32'h0000_0000; reg_wr_i = 1'b1; pc_i = 32'h800;
        @(negedge clk);
        reg_wr_i = 1'b0; ms = 32'h0; syscall_i = 1'b1;
        @(negedge clk);
        syscall_i = 1'b0;
        chk("R12 eval ignore request", {31'd0, exc_req_o}, 32'd0);
        @(negedge clk);
        chk("R12 eval ignore later", {31'd0, exc_req_o}, 32'd0);
        rd_chk("R12 eval ignore");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int          sel;
            logic [31:0] d, pc;
            logic        bd;
            logic [4:0]  oa;
            sel = int'($urandom % 6);
            d   = $urandom;
            pc  = {$urandom, 2'b00} & 32'h0FFF_FFFC;
            bd  = 1'($urandom % 2);
            case (sel)
                0: do_write(5'd12, d, pc, bd, "R3 R5 rnd status");
                1: do_write(5'd13, d, pc, bd, "R4 R5 rnd cause");
                2: do_write(5'd14, d, pc, bd, "R3 rnd epc");
                3: begin
                    oa = 5'($urandom % 32);
                    if (oa >= 5'd12 && oa <= 5'd14) oa = oa + 5'd4;
                    do_write(oa, d, pc, bd, "R2 rnd other");
                end
                4: do_rfe("R9 rnd");
                default: do_syscall(pc, bd, 1'b0, "R6 R8 rnd");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule